// File: doc/BRIEF.md
# Seven-Phase Pulse-Width Feedback Encoder

This block turns a 3-bit quantizer result into the drive for a feedback DAC that has only one current magnitude. Each sample period is split into seven equal phases. A fast clock supplies the phases, one clock per phase. During each phase the block either drives unit current (`pulse_o` high) with a polarity given by `sign_o`, or drives nothing. The number of positive phases and the number of negative phases together carry the code. The net charge in a period is therefore a whole number of sevenths of one full-period unit pulse.

Phases are assigned in a fixed interleaved order: phase ticks 0, 4, 1, 5, 2, 6, 3. Positive current takes the earliest slots of that order, negative current the next slots, and any remaining slot is idle. Every code then produces the same kind of pattern, and only the placement of the edges differs.

A code strobed in with `code_vld_i` is held as pending. It becomes active only on the `frame_i` strobe that marks a period start. A code that arrives in the middle of a period therefore waits for the next start. If no new start arrives, the pattern repeats every seven clocks.

Top module: `phase_pwm_encoder`

## Requirements
- R1: After reset `pulse_o` and `sign_o` are low, and they stay low until the first `frame_i` strobe, even if codes are strobed in before it.
- R2: Without a further `frame_i`, the phase count wraps after tick 6 and the same pattern repeats with a period of seven clocks.
- R3: Tick t of a period (t = 0..6) occupies slot (2·t) mod 7 of the fill order, so slots are visited by ticks 0, 4, 1, 5, 2, 6, 3. A phase is positive if its slot is below P, negative if its slot is below P+N, and idle otherwise.
- R4: The code is unsigned binary on `code_i[2:0]`. The positive phase count is P = c−1 for codes c = 1..7, and P = 0 for code 0.
- R5: The negative phase count is N = 7−c for codes c = 1..7, and N = 7 for code 0, which gives full negative scale.
- R6: Mid-scale code 3'b100 gives three positive and three negative phases, for zero net charge.
- R7: `sign_o` is high only while `pulse_o` is high. Idle phases drive `sign_o` low.
- R8: A `code_vld_i` strobe updates only the pending code. The active code changes only at `frame_i`, so a code strobed in mid-period has no effect until the next start.
- R9: When `code_vld_i` and `frame_i` are high in the same cycle, the newly strobed code is the one that becomes active.
- R10: Tick 0 of a period is driven on the outputs in the clock after the edge that samples `frame_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock, one cycle per seventh of a period |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_i | input | 3 | Quantizer code, unsigned |
| code_vld_i | input | 1 | Loads `code_i` into the pending register |
| frame_i | input | 1 | Period start; activates the pending code and restarts at tick 0 |
| pulse_o | output | 1 | Unit-current enable for the current phase |
| sign_o | output | 1 | Polarity: 1 positive, 0 negative or idle |

## Verification
All eight codes are swept phase by phase. Expected values come from the fill order and the positive and negative counts, so a wrong slot order, an off-by-one count or a swapped polarity each show up at a distinct tick. A period is left to run on without a new start, which separates wrap-around from a stall or reload. A code strobed at tick 3, a code strobed long before a start, and a code strobed in the same cycle as a start show whether the pending and active codes are kept apart and which one wins. Ticks before the first start separate a block that waits from one that emits a default pattern.

// File: rtl/phase_pwm_encoder.sv
module phase_pwm_encoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code_i,
  input  logic       code_vld_i,
  input  logic       frame_i,
  output logic       pulse_o,
  output logic       sign_o
);
  localparam int unsigned NPH  = 7;
  localparam int unsigned LAST = NPH - 1;

  logic [2:0] pend_q, act_q, ph_q;
  logic       run_q;

  logic [2:0] pend_n, code_n, ph_n, rank, pos_n, neg_n;
  logic [3:0] twice, act_cnt;
  logic       run_n;

  assign pend_n = code_vld_i ? code_i : pend_q;
  assign code_n = frame_i ? pend_n : act_q;
  assign run_n  = run_q | frame_i;
  assign ph_n   = (frame_i || ph_q == 3'(LAST)) ? 3'd0 : ph_q + 3'd1;

  assign twice  = {ph_n, 1'b0};
  assign rank   = (twice >= 4'(NPH)) ? 3'(twice - 4'(NPH)) : twice[2:0];

  assign pos_n   = (code_n == 3'd0) ? 3'd0 : code_n - 3'd1;
  assign neg_n   = (code_n == 3'd0) ? 3'd7 : 3'd7 - code_n;
  assign act_cnt = {1'b0, pos_n} + {1'b0, neg_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 3'd0;
      act_q   <= 3'd0;
      ph_q    <= 3'd0;
      run_q   <= 1'b0;
      pulse_o <= 1'b0;
      sign_o  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      if (frame_i) act_q <= pend_n;
      if (run_n)   ph_q  <= ph_n;
      run_q   <= run_n;
      pulse_o <= run_n && ({1'b0, rank} < act_cnt);
      sign_o  <= run_n && (rank < pos_n);
    end
  end
endmodule

module pwm7_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] code_i,
  input logic       code_vld_i,
  input logic       frame_i,
  input logic       pulse_o,
  input logic       sign_o
);
  logic       st_q;
  logic [3:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      cnt_q <= 4'd0;
    end else begin
      if (frame_i) st_q <= 1'b1;
      if (frame_i) cnt_q <= 4'd1;
      else if (cnt_q != 4'd0 && cnt_q != 4'd15) cnt_q <= cnt_q + 4'd1;
    end
  end

  assert_idle_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !st_q |-> (!pulse_o && !sign_o));

  assert_period_repeat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= 4'd8) |-> (pulse_o == $past(pulse_o, 7) && sign_o == $past(sign_o, 7)));

  assert_first_tick_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> pulse_o);

  assert_first_tick_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && code_vld_i && code_i >= 3'd2) |=> sign_o);

  assert_first_tick_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && code_vld_i && code_i <= 3'd1) |=> !sign_o);

  assert_sign_within_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sign_o |-> pulse_o);
endmodule

bind phase_pwm_encoder pwm7_chk u_chk (
  .clk(clk), .rst_n(rst_n), .code_i(code_i), .code_vld_i(code_vld_i),
  .frame_i(frame_i), .pulse_o(pulse_o), .sign_o(sign_o)
);

// File: tb/tb_phase_pwm_encoder.sv
module tb_phase_pwm_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] code_i = 3'd0;
  logic code_vld_i = 1'b0;
  logic frame_i = 1'b0;
  logic pulse_o, sign_o;

  int n_tests = 0;
  int n_fail = 0;
  int pos_seen, neg_seen;

  always #10 clk = ~clk;

  phase_pwm_encoder dut (
    .clk(clk), .rst_n(rst_n), .code_i(code_i), .code_vld_i(code_vld_i),
    .frame_i(frame_i), .pulse_o(pulse_o), .sign_o(sign_o)
  );

  function automatic int slot_of(int t);
    int ord[7] = '{1, 5, 2, 6, 3, 7, 4};
    for (int s = 0; s < 7; s++) if (ord[s] - 1 == t) return s;
    return 99;
  endfunction

  function automatic int pos_cnt(int c);
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic int neg_cnt(int c);
    return (c == 0) ? 7 : 7 - c;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_tick(string req, int c, int t);
    int s = slot_of(t);
    int ep = (s < pos_cnt(c) + neg_cnt(c)) ? 1 : 0;
    int es = (s < pos_cnt(c)) ? 1 : 0;
    chk(req, {pulse_o, sign_o}, {ep[0], es[0]});
    chk("R7", (sign_o && !pulse_o) ? 1 : 0, 0);
    if (pulse_o && sign_o) pos_seen++;
    if (pulse_o && !sign_o) neg_seen++;
  endtask

  task automatic start_period(int c, bit use_vld);
    @(negedge clk);
    if (use_vld) begin
      code_i = 3'(c);
      code_vld_i = 1'b1;
    end
    frame_i = 1'b1;
    @(negedge clk);
    code_vld_i = 1'b0;
    frame_i = 1'b0;
  endtask

  task automatic run_period(int c, string req);
    pos_seen = 0;
    neg_seen = 0;
    for (int t = 0; t < 7; t++) begin
      chk_tick(req, c, t);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle before first start, even with a code strobed in
    for (int i = 0; i < 6; i++) begin
      if (i == 2) begin code_i = 3'd7; code_vld_i = 1'b1; end
      else code_vld_i = 1'b0;
      @(negedge clk);
      chk("R1", {pulse_o, sign_o}, 0);
    end

    // R3/R4/R5/R6/R10: sweep every code
    for (int c = 0; c < 8; c++) begin
      start_period(c, 1'b1);
      chk("R10", pulse_o, 1);
      run_period(c, "R3");
      chk("R4", pos_seen, pos_cnt(c));
      chk("R5", neg_seen, neg_cnt(c));
      if (c == 4) chk("R6", pos_seen - neg_seen, 0);
      if (c == 5) begin
        run_period(c, "R2");
        run_period(c, "R2");
      end
    end

    // R8: code strobed mid-period waits for next start
    start_period(7, 1'b1);
    pos_seen = 0;
    neg_seen = 0;
    for (int t = 0; t < 7; t++) begin
      chk_tick("R8", 7, t);
      @(negedge clk);
      if (t == 3) begin code_i = 3'd0; code_vld_i = 1'b1; end
      else code_vld_i = 1'b0;
    end
    code_vld_i = 1'b0;
    start_period(0, 1'b0);
    run_period(0, "R8");

    // R8: pending code from a much earlier strobe
    @(negedge clk);
    code_i = 3'd3; code_vld_i = 1'b1;
    @(negedge clk);
    code_vld_i = 1'b0; code_i = 3'd6;
    repeat (4) @(negedge clk);
    start_period(3, 1'b0);
    run_period(3, "R8");

    // R9: strobe and start together, newest code wins
    @(negedge clk);
    code_i = 3'd2; code_vld_i = 1'b1;
    @(negedge clk);
    code_vld_i = 1'b0;
    start_period(6, 1'b1);
    run_period(6, "R9");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule